// File: doc/BRIEF.md
# Decoder Interrupt Status Controller

This block gathers event strobes from an audio/video bitstream decoder into one host-visible status byte and drives a single active-low interrupt line. Three events are recorded: the parser reporting a picture start code, the running system clock reference reaching a separately programmed audio compare value, and the start of active video. The start of active video is taken from the vertical-blanking bit of embedded SAV timing codes.

Alongside the flags, the block snapshots channel buffer read pointers. The video read pointer is captured on a picture start code and the audio read pointer on an audio sync code. The host can later relate these addresses to the buffer positions of incoming packet headers.

The host reaches everything through a simple synchronous register bus with a 4-bit byte address. Reading the status byte returns the flags and clears them in the same access. A mask byte keeps chosen flags from pulling the interrupt line low.

Top module: `dec_irq_status`

## Requirements
- R1: A status flag, once set, stays set until the host reads the status byte (address 0), however many cycles pass.
- R2: A read of address 0 returns the flags as they stand before the access and clears them at the following clock edge. If an event arrives in the same cycle as that read, its flag is set afterwards and is not lost.
- R3: irq_n is low exactly when some status flag is set and its mask bit is 0. The mask byte sits at address 1, with mask bit n belonging to status bit n. A masked flag is still recorded and readable.
- R4: A picture start code strobe sets status bit 0.
- R5: The audio compare value is SCR_W bits wide and is written as bytes at addresses 4 to 7, least significant byte at address 4. It resets to all ones. Status bit 1 is set on the cycle in which scr_now first equals it. While the equality persists, the bit is not set again.
- R6: Status bit 3 is set when a valid SAV code (tc_sav=1) carries vertical-blanking bit 0 and the previous SAV code carried 1. EAV codes (tc_sav=0) neither set it nor change the remembered blanking bit.
- R7: A picture start code captures vid_rdptr, and an audio sync code captures aud_rdptr. The video capture reads at addresses 8 to 11 and the audio capture at 12 to 15, least significant byte first, with bytes above PTR_W reading 0. Each new strobe overwrites the previous capture. An audio sync code sets no status bit.
- R8: Status bit 2 is reserved. A write to address 0 stores wdata bit 2 there, and it reads back as written. That write changes no event flag and does not affect irq_n.
- R9: After reset, all flags, the mask and both captures are 0 and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_evt | input | 1 | Picture start code detected (one-cycle strobe) |
| async_evt | input | 1 | Audio sync code detected (one-cycle strobe) |
| vid_rdptr | input | PTR_W | Current video channel read pointer |
| aud_rdptr | input | PTR_W | Current audio channel read pointer |
| scr_now | input | SCR_W | Running system clock reference |
| tc_valid | input | 1 | A timing code is present this cycle |
| tc_sav | input | 1 | 1 = start-of-active-video code, 0 = end code |
| tc_vbit | input | 1 | Vertical-blanking bit of the timing code |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_sel and bus_rd are high, else 0 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Each event source is driven alone, and then in combination with masking and with host reads. This separates a flag that is set from one that merely drives the line. The compare is tried with a value held equal for several cycles, and again after leaving and re-entering equality. This tells an edge-triggered match from a level one. Timing codes are sent as SAV/EAV mixes in which the blanking bit falls only on an EAV or stays low across SAVs, which exposes a detector that ignores the code type. A read coinciding with a strobe, and pointer strobes repeated with new values, check that no event is dropped and that captures are overwritten.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;
   localparam int ADDR_W  = 4;
   localparam int CAP_W   = 32;

   localparam int B_PSC   = 0;
   localparam int B_ACMP  = 1;
   localparam int B_RSV   = 2;
   localparam int B_BAV   = 3;

   localparam logic [ADDR_W-1:0] A_STATUS = 4'h0;
   localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;

   typedef enum logic [1:0] {
      PG_CTRL = 2'b00,
      PG_CMP  = 2'b01,
      PG_VCAP = 2'b10,
      PG_ACAP = 2'b11
   } page_e;
endpackage

// File: rtl/dis_cmp_match.sv
module dis_cmp_match #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ref_val,
   input  logic [W-1:0] cur_val,
   output logic         hit
);
   logic eq, eq_q;

   assign eq  = (ref_val == cur_val);
   assign hit = eq & ~eq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq;
   end

   AST_CMP_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit); // R5
endmodule

// File: rtl/dis_vblank_edge.sv
module dis_vblank_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tc_valid,
   input  logic tc_sav,
   input  logic tc_vbit,
   output logic active_start
);
   logic sav_seen;
   logic v_prev;

   assign sav_seen     = tc_valid & tc_sav;
   assign active_start = sav_seen & ~tc_vbit & v_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        v_prev <= 1'b0;
      else if (sav_seen) v_prev <= tc_vbit;
   end

   AST_BAV_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      active_start |=> !active_start); // R6
   AST_EAV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_valid && !tc_sav) |-> !active_start); // R6
endmodule

// File: rtl/dis_ptr_capture.sv
module dis_ptr_capture
   import dec_irq_pkg::*;
#(
   parameter int PTR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic [PTR_W-1:0] ptr,
   output logic [CAP_W-1:0] cap
);
   logic [PTR_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (evt) held <= ptr;
   end

   generate
      if (PTR_W < CAP_W) begin : g_pad
         assign cap = {{(CAP_W-PTR_W){1'b0}}, held};
      end else begin : g_full
         assign cap = held;
      end
   endgenerate

   AST_CAP_TAKES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (held == $past(ptr))); // R7
   AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(held)); // R7
endmodule

// File: rtl/dec_irq_status.sv
module dec_irq_status
   import dec_irq_pkg::*;
#(
   parameter int PTR_W   = 24,
   parameter int SCR_W   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psc_evt,
   input  logic              async_evt,
   input  logic [PTR_W-1:0]  vid_rdptr,
   input  logic [PTR_W-1:0]  aud_rdptr,
   input  logic [SCR_W-1:0]  scr_now,
   input  logic              tc_valid,
   input  logic              tc_sav,
   input  logic              tc_vbit,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_n
);
   localparam int CMP_BYTES = SCR_W / 8;

   generate
      if (SCR_W % 8 != 0 || SCR_W < 8 || SCR_W > CAP_W) begin : g_bad_scr
         $error("SCR_W must be a whole number of bytes, 8 to 32");
      end
      if (PTR_W < 1 || PTR_W > CAP_W) begin : g_bad_ptr
         $error("PTR_W must lie between 1 and 32");
      end
   endgenerate

   logic             wr_en, rd_st;
   logic             f_psc, f_acmp, f_bav, rsv_bit;
   logic [7:0]       mask_q;
   logic [SCR_W-1:0] cmp_val;
   logic [CAP_W-1:0] cmp32, vcap, acap;
   logic             acmp_hit, bav_hit;
   logic [3:0]       pend;
   logic [7:0]       status_byte, rd_mux;

   assign wr_en = bus_sel & bus_wr;
   assign rd_st = bus_sel & bus_rd & (bus_addr == A_STATUS);

   // event sources
   dis_cmp_match #(.W(SCR_W)) u_acmp (
      .clk(clk), .rst_n(rst_n), .ref_val(cmp_val), .cur_val(scr_now), .hit(acmp_hit));

   dis_vblank_edge u_bav (
      .clk(clk), .rst_n(rst_n), .tc_valid(tc_valid), .tc_sav(tc_sav),
      .tc_vbit(tc_vbit), .active_start(bav_hit));

   dis_ptr_capture #(.PTR_W(PTR_W)) u_vcap (
      .clk(clk), .rst_n(rst_n), .evt(psc_evt), .ptr(vid_rdptr), .cap(vcap));

   dis_ptr_capture #(.PTR_W(PTR_W)) u_acap (
      .clk(clk), .rst_n(rst_n), .evt(async_evt), .ptr(aud_rdptr), .cap(acap));

   // sticky flags, cleared by a status read unless re-fired in that cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_psc  <= 1'b0;
         f_acmp <= 1'b0;
         f_bav  <= 1'b0;
      end else begin
         f_psc  <= (f_psc  & ~rd_st) | psc_evt;
         f_acmp <= (f_acmp & ~rd_st) | acmp_hit;
         f_bav  <= (f_bav  & ~rd_st) | bav_hit;
      end
   end

   // host-written registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         rsv_bit <= 1'b0;
         cmp_val <= '1;
      end else if (wr_en) begin
         if (bus_addr == A_STATUS) rsv_bit <= bus_wdata[B_RSV];
         if (bus_addr == A_MASK)   mask_q  <= bus_wdata;
         for (int k = 0; k < CMP_BYTES; k++) begin
            if (bus_addr == {PG_CMP, 2'(k)}) cmp_val[8*k +: 8] <= bus_wdata;
         end
      end
   end

   generate
      if (SCR_W < CAP_W) begin : g_cmp_pad
         assign cmp32 = {{(CAP_W-SCR_W){1'b0}}, cmp_val};
      end else begin : g_cmp_full
         assign cmp32 = cmp_val;
      end
   endgenerate

   // read path
   always_comb begin
      status_byte         = '0;
      status_byte[B_PSC]  = f_psc;
      status_byte[B_ACMP] = f_acmp;
      status_byte[B_RSV]  = rsv_bit;
      status_byte[B_BAV]  = f_bav;
   end

   always_comb begin
      rd_mux = '0;
      case (page_e'(bus_addr[3:2]))
         PG_CTRL: begin
            if (bus_addr == A_STATUS)    rd_mux = status_byte;
            else if (bus_addr == A_MASK) rd_mux = mask_q;
         end
         PG_CMP:  rd_mux = cmp32[{bus_addr[1:0], 3'b000} +: 8];
         PG_VCAP: rd_mux = vcap[{bus_addr[1:0], 3'b000} +: 8];
         PG_ACAP: rd_mux = acap[{bus_addr[1:0], 3'b000} +: 8];
         default: rd_mux = '0;
      endcase
   end

   assign bus_rdata = (bus_sel & bus_rd) ? rd_mux : 8'h00;

   // interrupt line
   assign pend = {f_bav & ~mask_q[B_BAV], 1'b0,
                  f_acmp & ~mask_q[B_ACMP], f_psc & ~mask_q[B_PSC]};

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= ~|pend;
         end
         assign irq_n = irq_q;
      end else begin : g_irq_comb
         assign irq_n = ~|pend;

         AST_PSC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (psc_evt && !mask_q[B_PSC] && !(wr_en && bus_addr == A_MASK)) |=> !irq_n); // R3
      end
   endgenerate

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_st |=> ((f_psc >= $past(f_psc)) && (f_acmp >= $past(f_acmp)) && (f_bav >= $past(f_bav)))); // R1
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_st && !psc_evt && !acmp_hit && !bav_hit) |=> (!f_psc && !f_acmp && !f_bav)); // R2
   AST_READ_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_st && psc_evt) |=> f_psc); // R2
   AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == A_STATUS && !psc_evt && !acmp_hit && !bav_hit) |=> $stable({f_psc, f_acmp, f_bav})); // R8
endmodule

// File: tb/dec_irq_status_tb_top.sv
module dec_irq_status_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psc_evt = 0, async_evt = 0;
   logic [23:0] vid_rdptr = '0, aud_rdptr = '0;
   logic [31:0] scr_now = '0;
   logic        tc_valid = 0, tc_sav = 0, tc_vbit = 0;
   logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_n;

   int n_chk = 0, n_fail = 0;
   bit live = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dec_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .psc_evt(psc_evt), .async_evt(async_evt),
      .vid_rdptr(vid_rdptr), .aud_rdptr(aud_rdptr), .scr_now(scr_now),
      .tc_valid(tc_valid), .tc_sav(tc_sav), .tc_vbit(tc_vbit),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

   // behavioural reference model
   bit        m_psc, m_acmp, m_bav, m_rsv, m_eq_prev, m_vlast;
   bit [7:0]  m_mask;
   bit [31:0] m_cmp, m_vcap, m_acap;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psc = 0; m_acmp = 0; m_bav = 0; m_rsv = 0; m_eq_prev = 0; m_vlast = 0;
         m_mask = 0; m_cmp = 32'hFFFF_FFFF; m_vcap = 0; m_acap = 0;
      end else begin
         bit rd0, hit_a, hit_b, eq;
         rd0   = bus_sel && bus_rd && bus_addr == 0;
         eq    = (scr_now == m_cmp);
         hit_a = eq && !m_eq_prev;
         hit_b = tc_valid && tc_sav && !tc_vbit && m_vlast;
         m_eq_prev = eq;
         if (tc_valid && tc_sav) m_vlast = tc_vbit;
         if (rd0) begin m_psc = 0; m_acmp = 0; m_bav = 0; end
         if (psc_evt) begin m_psc = 1; m_vcap = {8'h00, vid_rdptr}; end
         if (async_evt) m_acap = {8'h00, aud_rdptr};
         if (hit_a) m_acmp = 1;
         if (hit_b) m_bav = 1;
         if (bus_sel && bus_wr) begin
            if (bus_addr == 0) m_rsv = bus_wdata[2];
            if (bus_addr == 1) m_mask = bus_wdata;
            if (bus_addr[3:2] == 2'b01) m_cmp[8*bus_addr[1:0] +: 8] = bus_wdata;
         end
      end
   end

   function automatic [7:0] m_read(input [3:0] a);
      case (a[3:2])
         2'b00:   m_read = (a == 0) ? {4'b0, m_bav, m_rsv, m_acmp, m_psc} : (a == 1) ? m_mask : 8'h00;
         2'b01:   m_read = m_cmp[8*a[1:0] +: 8];
         2'b10:   m_read = m_vcap[8*a[1:0] +: 8];
         default: m_read = m_acap[8*a[1:0] +: 8];
      endcase
   endfunction

   task automatic check(input string tag, input [31:0] act, input [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock, then compare against the model in the low phase
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      if (live) begin
         check("R3 irq_n vs model", {31'b0, irq_n},
               {31'b0, ~|({m_bav, 1'b0, m_acmp, m_psc} & ~m_mask[3:0])});
         check("R2 rdata vs model", {24'b0, bus_rdata},
               {24'b0, (bus_sel && bus_rd) ? m_read(bus_addr) : 8'h00});
      end
   endtask

   task automatic rd_chk(input [3:0] a, input [7:0] exp, input string tag);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1;
      check(tag, {24'b0, bus_rdata}, {24'b0, exp});
      step();
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic wr(input [3:0] a, input [7:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic tcode(input bit sav, input bit v);
      tc_valid = 1; tc_sav = sav; tc_vbit = v;
      step();
      tc_valid = 0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      live = 1;
      // R9 reset state
      check("R9 irq_n after reset", {31'b0, irq_n}, 32'd1);
      rd_chk(4'h0, 8'h00, "R9 status after reset");
      rd_chk(4'h1, 8'h00, "R9 mask after reset");
      rd_chk(4'h9, 8'h00, "R9 video capture after reset");
      rd_chk(4'h4, 8'hFF, "R5 compare reset value");

      // R4 / R7 picture start code
      vid_rdptr = 24'h123456; psc_evt = 1; step(); psc_evt = 0;
      check("R4 irq_n low after psc", {31'b0, irq_n}, 32'd0);
      rd_chk(4'h0, 8'h01, "R4 status bit0");
      rd_chk(4'h0, 8'h00, "R2 cleared by read");
      check("R2 irq_n released", {31'b0, irq_n}, 32'd1);
      rd_chk(4'h8, 8'h56, "R7 video capture byte0");
      rd_chk(4'hA, 8'h12, "R7 video capture byte2");
      rd_chk(4'hB, 8'h00, "R7 video capture pad byte");

      // R1 stickiness
      psc_evt = 1; step(); psc_evt = 0;
      repeat (6) step();
      rd_chk(4'h0, 8'h01, "R1 flag held");

      // R7 audio sync capture and overwrite
      aud_rdptr = 24'hABCDEF; async_evt = 1; step(); async_evt = 0;
      rd_chk(4'hC, 8'hEF, "R7 audio capture byte0");
      rd_chk(4'hE, 8'hAB, "R7 audio capture byte2");
      rd_chk(4'h0, 8'h00, "R7 sync sets no flag");
      aud_rdptr = 24'h000102; async_evt = 1; step(); async_evt = 0;
      rd_chk(4'hC, 8'h02, "R7 audio capture overwritten");

      // R5 audio compare
      scr_now = 32'h1122_3343;
      wr(4'h4, 8'h44); wr(4'h5, 8'h33); wr(4'h6, 8'h22); wr(4'h7, 8'h11);
      rd_chk(4'h0, 8'h00, "R5 no match yet");
      scr_now = 32'h1122_3344; step();
      repeat (3) step();
      rd_chk(4'h0, 8'h02, "R5 match sets bit1");
      rd_chk(4'h0, 8'h00, "R5 no refire while equal");
      scr_now = 32'h1122_3345; step();
      scr_now = 32'h1122_3344; step();
      rd_chk(4'h0, 8'h02, "R5 refire after re-entry");

      // R3 masking
      wr(4'h1, 8'h0B);
      psc_evt = 1; step(); psc_evt = 0;
      check("R3 masked irq_n stays high", {31'b0, irq_n}, 32'd1);
      wr(4'h1, 8'h0A);
      check("R3 unmask exposes pending flag", {31'b0, irq_n}, 32'd0);
      rd_chk(4'h0, 8'h01, "R3 masked flag recorded");
      wr(4'h1, 8'h00);

      // R6 begin active video
      tcode(1, 1); tcode(0, 0);
      rd_chk(4'h0, 8'h00, "R6 EAV ignored");
      tcode(1, 0);
      rd_chk(4'h0, 8'h08, "R6 SAV blanking fall");
      tcode(0, 1); tcode(1, 0);
      rd_chk(4'h0, 8'h00, "R6 no start without blank SAV");

      // R2 read racing an event
      psc_evt = 1;
      rd_chk(4'h0, 8'h00, "R2 read during event");
      psc_evt = 0;
      rd_chk(4'h0, 8'h01, "R2 event not lost");

      // R8 reserved bit
      wr(4'h0, 8'h04);
      rd_chk(4'h0, 8'h04, "R8 reserved readback");
      check("R8 irq_n unaffected", {31'b0, irq_n}, 32'd1);
      wr(4'h0, 8'hFB);
      rd_chk(4'h0, 8'h00, "R8 write sets no flag");
      check("R8 irq_n after write", {31'b0, irq_n}, 32'd1);

      repeat (2) step();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule